// File: doc/BRIEF.md
# Register Dependence Chain Tracker

This block watches the retire stream of a core and keeps, for each architectural register, a short summary of how that register's current value was produced. A value that came from a load with a confident stride entry starts a chain. Each simple ALU operation that consumes chain values extends it. The summary stores two things: a saturating count of the ALU operations on the chain, and an ordered list of the stride-table pointers of the loads feeding it. A value that came from an unpredictable load, from a complex operation, or from a chain that grew past its limits is marked unusable.

When a branch retires and the default predictor had low confidence in it, the tracker merges the summaries of the branch's source registers. It returns one verdict: whether the branch depends only on predictable loads through a chain short enough to precompute, together with the operation count and the merged list of load pointers. A branch table downstream uses this verdict to decide whether to allocate an entry.

Retire events arrive on a valid/ready stream. Verdicts leave on a second valid/ready stream that holds one result. An event is taken on a rising clock edge where `ev_valid` and `ev_ready` are both high. `ev_ready` is low only while a verdict is waiting and `res_ready` is low. A waiting verdict keeps every field stable until a cycle in which `res_ready` is high. A new verdict may replace the old one on that same edge.

Top module: `rdt_chain_tracker`

## Requirements
- R1: After reset, no verdict is pending. Every register except register 0 is unusable, so a low-confidence branch on such a register reports `res_chain_ok`=0, `res_ops`=7 (all ones) and `res_nloads`=0.
- R2: A load event (`ev_kind`=00) with `ev_confident`=1 sets its destination to 0 operations and a one-entry list holding `ev_ptr` in slot 0.
- R3: A load event with `ev_confident`=0 makes its destination unusable: count all ones, list empty. This holds whatever the register held before.
- R4: A simple ALU event (`ev_kind`=01) writes operations = count(src_a) + count(src_b) + 1. It writes the list of src_a's pointers followed by src_b's pointers, with duplicates kept. When `ev_src_b_used`=0, src_b contributes nothing. Reading a source that is also the destination uses the value from before the event.
- R5: A merge is unusable if any source it reads is unusable, if its operation total exceeds MAX_OPS (3), or if its pointer total exceeds MAX_LOADS (5). An unusable merge writes count all ones and an empty list.
- R6: A complex ALU event (`ev_kind`=10) makes its destination unusable.
- R7: A branch event (`ev_kind`=11) with `ev_lowconf`=1 produces exactly one verdict, one cycle after acceptance. The verdict merges the sources as in R4 but adds no operation for the branch itself. `res_chain_ok` is 1 only when the merge is usable and holds at least one pointer. A branch with `ev_lowconf`=0 produces no verdict. Branches never change register state.
- R8: Register 0 always reads as 0 operations with an empty list. Writes to it are dropped.
- R9: Pointer slot i occupies `res_ptrs[i*PTR_W +: PTR_W]`, and unused slots are zero. A pending verdict with `res_ready`=0 holds all of its fields and stalls `ev_ready`. A stalled event takes effect exactly once, on the edge where it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Retire event present |
| ev_ready | output | 1 | Tracker can take an event |
| ev_kind | input | 2 | 00 load, 01 simple ALU, 10 complex ALU, 11 branch |
| ev_dst | input | REG_W | Destination register (loads and ALU ops) |
| ev_src_a | input | REG_W | First source register |
| ev_src_b | input | REG_W | Second source register |
| ev_src_b_used | input | 1 | Second source is meaningful |
| ev_ptr | input | PTR_W | Stride-table pointer of a load |
| ev_confident | input | 1 | Load's stride entry is confident |
| ev_lowconf | input | 1 | Default predictor has low confidence in the branch |
| res_valid | output | 1 | Verdict pending |
| res_ready | input | 1 | Consumer takes the verdict |
| res_chain_ok | output | 1 | Branch chain is usable |
| res_ops | output | CNT_W | Operation count (all ones when unusable) |
| res_nloads | output | LEN_W | Number of pointers in the list |
| res_ptrs | output | MAX_LOADS*PTR_W | Merged pointer list |

## Verification
A corrupted register entry stays hidden until a low-confidence branch reads that register, directly or through an ALU event that copied it. It then appears in the verdict one cycle after that branch is accepted, as a wrong count, a wrong pointer order or a wrong verdict bit. The stimulus therefore reads every register it writes within a few events of the write. It covers same-register sources, register 0 as a source and as a destination, chains that hit the limits exactly and by one over, and unusable values fed onward into later operations. Stalls on the verdict port are checked for held fields and for an event applied exactly once.

// File: rtl/rdt_pkg.sv
`timescale 1ns/1ps
package rdt_pkg;

  // Retire event class, as carried on ev_kind
  typedef enum logic [1:0] {
    EV_LOAD    = 2'b00,
    EV_ALU     = 2'b01,
    EV_COMPLEX = 2'b10,
    EV_BRANCH  = 2'b11
  } ev_kind_e;

endpackage

// File: rtl/rdt_merge.sv
`timescale 1ns/1ps
// Combines two register summaries into one, enforcing the chain limits.
module rdt_merge #(
  parameter int PTR_W     = 6,
  parameter int MAX_LOADS = 5,
  parameter int MAX_OPS   = 3,
  parameter int CNT_W     = 3,
  parameter int LEN_W     = 3,
  localparam int LIST_W   = MAX_LOADS * PTR_W,
  localparam int SUM_W    = CNT_W + 2
) (
  input  logic [CNT_W-1:0]  a_cnt,
  input  logic [LEN_W-1:0]  a_len,
  input  logic [LIST_W-1:0] a_list,
  input  logic [CNT_W-1:0]  b_cnt,
  input  logic [LEN_W-1:0]  b_len,
  input  logic [LIST_W-1:0] b_list,
  input  logic              b_used,
  input  logic              add_op,
  output logic [CNT_W-1:0]  m_cnt,
  output logic [LEN_W-1:0]  m_len,
  output logic [LIST_W-1:0] m_list,
  output logic              m_ok
);
  localparam logic [CNT_W-1:0] CNT_BAD = {CNT_W{1'b1}};

  logic [SUM_W-1:0] op_sum;
  logic [LEN_W:0]   a_len_x, b_len_x, len_sum;
  logic             a_bad, b_bad;

  always_comb begin
    a_bad   = (a_cnt == CNT_BAD);
    b_bad   = b_used && (b_cnt == CNT_BAD);
    a_len_x = {1'b0, a_len};
    b_len_x = b_used ? {1'b0, b_len} : '0;
    op_sum  = SUM_W'(a_cnt) + (b_used ? SUM_W'(b_cnt) : '0) + SUM_W'(add_op);
    len_sum = a_len_x + b_len_x;
    m_ok    = !a_bad && !b_bad
              && (op_sum <= SUM_W'(MAX_OPS))
              && (len_sum <= (LEN_W+1)'(MAX_LOADS));
    m_cnt   = m_ok ? op_sum[CNT_W-1:0] : CNT_BAD;
    m_len   = m_ok ? len_sum[LEN_W-1:0] : '0;
  end

  // Each output slot takes from list a, then continues into list b
  for (genvar s = 0; s < MAX_LOADS; s++) begin : g_slot
    logic [LEN_W:0] b_off;
    assign b_off = (LEN_W+1)'(s) - a_len_x;
    assign m_list[s*PTR_W +: PTR_W] =
        !m_ok                        ? '0 :
        ((LEN_W+1)'(s) < a_len_x)    ? a_list[s*PTR_W +: PTR_W] :
        (b_off < b_len_x)            ? b_list[int'(b_off)*PTR_W +: PTR_W] :
                                       '0;
  end

endmodule

// File: rtl/rdt_regfile.sv
`timescale 1ns/1ps
// Per-register chain summaries; register 0 reads as an empty, zero-op chain.
module rdt_regfile #(
  parameter int NUM_REGS = 32,
  parameter int CNT_W    = 3,
  parameter int LEN_W    = 3,
  parameter int LIST_W   = 30,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  rd_a_idx,
  input  logic [REG_W-1:0]  rd_b_idx,
  output logic [CNT_W-1:0]  rd_a_cnt,
  output logic [LEN_W-1:0]  rd_a_len,
  output logic [LIST_W-1:0] rd_a_list,
  output logic [CNT_W-1:0]  rd_b_cnt,
  output logic [LEN_W-1:0]  rd_b_len,
  output logic [LIST_W-1:0] rd_b_list,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_idx,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [LIST_W-1:0] wr_list
);
  localparam logic [CNT_W-1:0] CNT_BAD = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  cnt_q  [NUM_REGS];
  logic [LEN_W-1:0]  len_q  [NUM_REGS];
  logic [LIST_W-1:0] list_q [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        cnt_q[r]  <= CNT_BAD;
        len_q[r]  <= '0;
        list_q[r] <= '0;
      end
    end else if (wr_en && (wr_idx != '0)) begin
      cnt_q[wr_idx]  <= wr_cnt;
      len_q[wr_idx]  <= wr_len;
      list_q[wr_idx] <= wr_list;
    end
  end

  assign rd_a_cnt  = (rd_a_idx == '0) ? '0 : cnt_q[rd_a_idx];
  assign rd_a_len  = (rd_a_idx == '0) ? '0 : len_q[rd_a_idx];
  assign rd_a_list = (rd_a_idx == '0) ? '0 : list_q[rd_a_idx];
  assign rd_b_cnt  = (rd_b_idx == '0) ? '0 : cnt_q[rd_b_idx];
  assign rd_b_len  = (rd_b_idx == '0) ? '0 : len_q[rd_b_idx];
  assign rd_b_list = (rd_b_idx == '0) ? '0 : list_q[rd_b_idx];

endmodule

// File: rtl/rdt_chain_tracker.sv
`timescale 1ns/1ps
// Follows retiring loads and ALU ops per register and judges branch chains.
module rdt_chain_tracker #(
  parameter int NUM_REGS  = 32,
  parameter int PTR_W     = 6,
  parameter int MAX_LOADS = 5,
  parameter int MAX_OPS   = 3,
  parameter int CNT_W     = 3,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int LEN_W    = $clog2(MAX_LOADS + 1),
  localparam int LIST_W   = MAX_LOADS * PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_kind,
  input  logic [REG_W-1:0]  ev_dst,
  input  logic [REG_W-1:0]  ev_src_a,
  input  logic [REG_W-1:0]  ev_src_b,
  input  logic              ev_src_b_used,
  input  logic [PTR_W-1:0]  ev_ptr,
  input  logic              ev_confident,
  input  logic              ev_lowconf,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_chain_ok,
  output logic [CNT_W-1:0]  res_ops,
  output logic [LEN_W-1:0]  res_nloads,
  output logic [LIST_W-1:0] res_ptrs
);
  import rdt_pkg::*;

  localparam logic [CNT_W-1:0] CNT_BAD = {CNT_W{1'b1}};

  ev_kind_e          kind;
  logic              accept, new_verdict;
  logic [CNT_W-1:0]  a_cnt, b_cnt, m_cnt, wr_cnt;
  logic [LEN_W-1:0]  a_len, b_len, m_len, wr_len;
  logic [LIST_W-1:0] a_list, b_list, m_list, wr_list;
  logic              m_ok, wr_en;

  logic              res_valid_q, res_ok_q;
  logic [CNT_W-1:0]  res_ops_q;
  logic [LEN_W-1:0]  res_len_q;
  logic [LIST_W-1:0] res_list_q;

  assign kind        = ev_kind_e'(ev_kind);
  assign ev_ready    = !res_valid_q || res_ready;
  assign accept      = ev_valid && ev_ready;
  assign new_verdict = accept && (kind == EV_BRANCH) && ev_lowconf;

  rdt_regfile #(
    .NUM_REGS (NUM_REGS),
    .CNT_W    (CNT_W),
    .LEN_W    (LEN_W),
    .LIST_W   (LIST_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (ev_src_a),
    .rd_b_idx  (ev_src_b),
    .rd_a_cnt  (a_cnt),
    .rd_a_len  (a_len),
    .rd_a_list (a_list),
    .rd_b_cnt  (b_cnt),
    .rd_b_len  (b_len),
    .rd_b_list (b_list),
    .wr_en     (wr_en),
    .wr_idx    (ev_dst),
    .wr_cnt    (wr_cnt),
    .wr_len    (wr_len),
    .wr_list   (wr_list)
  );

  // One merge unit serves both ALU writes (+1 op) and branch verdicts (+0)
  rdt_merge #(
    .PTR_W     (PTR_W),
    .MAX_LOADS (MAX_LOADS),
    .MAX_OPS   (MAX_OPS),
    .CNT_W     (CNT_W),
    .LEN_W     (LEN_W)
  ) u_merge (
    .a_cnt  (a_cnt),
    .a_len  (a_len),
    .a_list (a_list),
    .b_cnt  (b_cnt),
    .b_len  (b_len),
    .b_list (b_list),
    .b_used (ev_src_b_used),
    .add_op (kind == EV_ALU),
    .m_cnt  (m_cnt),
    .m_len  (m_len),
    .m_list (m_list),
    .m_ok   (m_ok)
  );

  // Next summary for the destination register
  always_comb begin
    wr_en   = accept && (kind != EV_BRANCH);
    wr_cnt  = CNT_BAD;
    wr_len  = '0;
    wr_list = '0;
    unique case (kind)
      EV_LOAD: begin
        if (ev_confident) begin
          wr_cnt  = '0;
          wr_len  = LEN_W'(1);
          wr_list = LIST_W'(ev_ptr);
        end
      end
      EV_ALU: begin
        wr_cnt  = m_cnt;
        wr_len  = m_len;
        wr_list = m_list;
      end
      default: ;
    endcase
  end

  // One-entry verdict register on the output stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_ok_q    <= 1'b0;
      res_ops_q   <= '0;
      res_len_q   <= '0;
      res_list_q  <= '0;
    end else if (new_verdict) begin
      res_valid_q <= 1'b1;
      res_ok_q    <= m_ok && (m_len != '0);
      res_ops_q   <= m_cnt;
      res_len_q   <= m_len;
      res_list_q  <= m_list;
    end else if (res_ready) begin
      res_valid_q <= 1'b0;
    end
  end

  assign res_valid    = res_valid_q;
  assign res_chain_ok = res_ok_q;
  assign res_ops      = res_ops_q;
  assign res_nloads   = res_len_q;
  assign res_ptrs     = res_list_q;

endmodule

// File: rtl/rdt_chain_tracker_chk.sv
`timescale 1ns/1ps
module rdt_chain_tracker_chk #(
  parameter int NUM_REGS  = 32,
  parameter int PTR_W     = 6,
  parameter int MAX_LOADS = 5,
  parameter int MAX_OPS   = 3,
  parameter int CNT_W     = 3,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int LEN_W    = $clog2(MAX_LOADS + 1),
  localparam int LIST_W   = MAX_LOADS * PTR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [1:0]        ev_kind,
  input logic              ev_lowconf,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_chain_ok,
  input logic [CNT_W-1:0]  res_ops,
  input logic [LEN_W-1:0]  res_nloads,
  input logic [LIST_W-1:0] res_ptrs
);

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_chain_ok) && $stable(res_ops)
                                && $stable(res_nloads) && $stable(res_ptrs));

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !ev_ready);

  // R7
  verdict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(ev_valid && ev_ready && ev_kind == 2'b11 && ev_lowconf));

  // R7
  no_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && !(ev_kind == 2'b11 && ev_lowconf) |=> !res_valid);

  // R5
  ok_limits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_chain_ok |-> res_nloads != '0 && res_nloads <= LEN_W'(MAX_LOADS)
                                  && res_ops <= CNT_W'(MAX_OPS));

  // R5
  bad_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_chain_ok |-> res_nloads == '0 && res_ptrs == '0);

endmodule

bind rdt_chain_tracker rdt_chain_tracker_chk #(
  .NUM_REGS  (NUM_REGS),
  .PTR_W     (PTR_W),
  .MAX_LOADS (MAX_LOADS),
  .MAX_OPS   (MAX_OPS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_valid     (ev_valid),
  .ev_ready     (ev_ready),
  .ev_kind      (ev_kind),
  .ev_lowconf   (ev_lowconf),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_chain_ok (res_chain_ok),
  .res_ops      (res_ops),
  .res_nloads   (res_nloads),
  .res_ptrs     (res_ptrs)
);

// File: tb/test_rdt_chain_tracker.sv
`timescale 1ns/1ps
module test_rdt_chain_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [1:0]  ev_kind = '0;
  logic [4:0]  ev_dst = '0, ev_src_a = '0, ev_src_b = '0;
  logic        ev_src_b_used = 1'b0;
  logic [5:0]  ev_ptr = '0;
  logic        ev_confident = 1'b0, ev_lowconf = 1'b0;
  logic        res_ready = 1'b1;

  logic        ev_ready, res_valid, res_chain_ok;
  logic [2:0]  res_ops, res_nloads;
  logic [29:0] res_ptrs;

  logic        n_ev_ready, n_valid, n_ok;
  logic [2:0]  n_ops;
  logic [1:0]  n_nloads;
  logic [11:0] n_ptrs;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  rdt_chain_tracker i_rdt_chain_tracker (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_dst(ev_dst), .ev_src_a(ev_src_a), .ev_src_b(ev_src_b),
    .ev_src_b_used(ev_src_b_used), .ev_ptr(ev_ptr), .ev_confident(ev_confident),
    .ev_lowconf(ev_lowconf), .res_valid(res_valid), .res_ready(res_ready),
    .res_chain_ok(res_chain_ok), .res_ops(res_ops), .res_nloads(res_nloads),
    .res_ptrs(res_ptrs));

  // Second copy with a two-pointer list, to reach the pointer limit
  rdt_chain_tracker #(.MAX_LOADS(2)) i_rdt_chain_tracker_narrow (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(n_ev_ready),
    .ev_kind(ev_kind), .ev_dst(ev_dst), .ev_src_a(ev_src_a), .ev_src_b(ev_src_b),
    .ev_src_b_used(ev_src_b_used), .ev_ptr(ev_ptr), .ev_confident(ev_confident),
    .ev_lowconf(ev_lowconf), .res_valid(n_valid), .res_ready(res_ready),
    .res_chain_ok(n_ok), .res_ops(n_ops), .res_nloads(n_nloads), .res_ptrs(n_ptrs));

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected=<20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Presents one event at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [1:0] k, input int dst, input int sa, input int sb,
                      input bit ub, input int ptr, input bit conf, input bit lowc);
    @(negedge clk);
    ev_kind = k; ev_dst = 5'(dst); ev_src_a = 5'(sa); ev_src_b = 5'(sb);
    ev_src_b_used = ub; ev_ptr = 6'(ptr); ev_confident = conf; ev_lowconf = lowc;
    ev_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic expect_verdict(input string req, input bit ok, input int ops,
                                input int n, input longint ptrs);
    chk(req, "res_valid", res_valid, 1);
    chk(req, "res_chain_ok", res_chain_ok, ok);
    chk(req, "res_ops", res_ops, ops);
    chk(req, "res_nloads", res_nloads, n);
    chk(req, "res_ptrs", res_ptrs, ptrs);
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  dst;
    logic [4:0]  sa;
    logic [4:0]  sb;
    logic        ub;
    logic [5:0]  ptr;
    logic        conf;
    logic        lowc;
    logic        expr;
    logic        eok;
    logic [2:0]  eops;
    logic [2:0]  en;
    logic [29:0] eptr;
    logic [3:0]  req;
  } vec_t;

  localparam logic [1:0] LD = 2'b00, AL = 2'b01, CX = 2'b10, BR = 2'b11;
  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{BR, 5'd0, 5'd5,  5'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 3'd7, 3'd0, 30'd0,        4'd1}, // R1 untouched reg
    '{LD, 5'd1, 5'd0,  5'd0,  1'b0, 6'd3,  1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd2}, // R2
    '{BR, 5'd0, 5'd1,  5'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 3'd1, 30'd3,        4'd2},
    '{LD, 5'd2, 5'd0,  5'd0,  1'b0, 6'd9,  1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd2},
    '{AL, 5'd3, 5'd1,  5'd2,  1'b1, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd4}, // R4
    '{BR, 5'd0, 5'd3,  5'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 3'd2, 30'd579,      4'd4},
    '{AL, 5'd4, 5'd3,  5'd3,  1'b1, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd4}, // duplicates kept
    '{BR, 5'd0, 5'd4,  5'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 3'd4, 30'd2372163,  4'd4},
    '{AL, 5'd5, 5'd4,  5'd0,  1'b1, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd5}, // R5 ops 4
    '{BR, 5'd0, 5'd5,  5'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 3'd7, 3'd0, 30'd0,        4'd5},
    '{AL, 5'd6, 5'd5,  5'd1,  1'b1, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd5}, // propagate
    '{BR, 5'd0, 5'd6,  5'd1,  1'b1, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 3'd7, 3'd0, 30'd0,        4'd5},
    '{LD, 5'd7, 5'd0,  5'd0,  1'b0, 6'd12, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd3}, // R3
    '{BR, 5'd0, 5'd7,  5'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 3'd7, 3'd0, 30'd0,        4'd3},
    '{LD, 5'd1, 5'd0,  5'd0,  1'b0, 6'd20, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd3}, // overwrite valid
    '{BR, 5'd0, 5'd1,  5'd2,  1'b1, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 3'd7, 3'd0, 30'd0,        4'd3},
    '{LD, 5'd1, 5'd0,  5'd0,  1'b0, 6'd33, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd2},
    '{BR, 5'd0, 5'd1,  5'd2,  1'b1, 6'd0,  1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 3'd2, 30'd609,      4'd7}, // R7 two sources
    '{AL, 5'd2, 5'd2,  5'd1,  1'b1, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd4}, // src == dst
    '{BR, 5'd0, 5'd2,  5'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 3'd2, 30'd2121,     4'd4},
    '{CX, 5'd2, 5'd1,  5'd0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd6}, // R6
    '{BR, 5'd0, 5'd2,  5'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 3'd7, 3'd0, 30'd0,        4'd6},
    '{BR, 5'd0, 5'd1,  5'd0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd7}, // confident branch
    '{LD, 5'd0, 5'd0,  5'd0,  1'b0, 6'd5,  1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd8}, // R8 write dropped
    '{BR, 5'd0, 5'd0,  5'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 30'd0,        4'd8},
    '{AL, 5'd8, 5'd0,  5'd1,  1'b1, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd8},
    '{BR, 5'd0, 5'd8,  5'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 3'd1, 30'd33,       4'd8},
    '{LD, 5'd10, 5'd0, 5'd0,  1'b0, 6'd1,  1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd2},
    '{LD, 5'd11, 5'd0, 5'd0,  1'b0, 6'd2,  1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd2},
    '{AL, 5'd12, 5'd10, 5'd11, 1'b1, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd4},
    '{AL, 5'd13, 5'd12, 5'd12, 1'b1, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 30'd0,        4'd4},
    '{BR, 5'd0, 5'd13, 5'd10, 1'b1, 6'd0,  1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 3'd5, 30'd17305729, 4'd7}, // full list
    '{BR, 5'd0, 5'd13, 5'd12, 1'b1, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 3'd7, 3'd0, 30'd0,        4'd5}  // ops 4 at branch
  };

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "res_valid after reset", res_valid, 0);
    chk("R1", "ev_ready after reset", ev_ready, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string rq;
      v  = VEC[i];
      rq = $sformatf("R%0d", v.req);
      send(v.kind, v.dst, v.sa, v.sb, v.ub, v.ptr, v.conf, v.lowc);
      if (v.expr) expect_verdict(rq, v.eok, v.eops, v.en, v.eptr);
      else        chk(rq, "res_valid", res_valid, 0);
    end

    // R9: back-pressure on the verdict port
    @(negedge clk);
    res_ready = 1'b0;
    send(BR, 0, 1, 0, 0, 0, 0, 1);
    expect_verdict("R9", 1, 0, 1, 33);
    ev_kind = LD; ev_dst = 5'd9; ev_ptr = 6'd7; ev_confident = 1'b1;
    ev_src_b_used = 1'b0; ev_lowconf = 1'b0; ev_valid = 1'b1;
    #1 chk("R9", "ev_ready while stalled", ev_ready, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9", "res_valid held", res_valid, 1);
    chk("R9", "res_ptrs held", res_ptrs, 33);
    chk("R9", "ev_ready still low", ev_ready, 0);
    res_ready = 1'b1;
    #1 chk("R9", "ev_ready on release", ev_ready, 1);
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R9", "res_valid cleared", res_valid, 0);
    send(BR, 0, 9, 0, 0, 0, 0, 1);
    expect_verdict("R9", 1, 0, 1, 7);

    // R5: pointer limit, seen on the two-pointer copy
    send(LD, 20, 0, 0, 0, 4, 1, 0);
    send(LD, 21, 0, 0, 0, 5, 1, 0);
    send(AL, 22, 20, 21, 1, 0, 0, 0);
    send(BR, 0, 22, 0, 0, 0, 0, 1);
    chk("R5", "narrow two pointers ok", n_ok, 1);
    chk("R5", "narrow ptrs", n_ptrs, 324);
    send(BR, 0, 22, 20, 1, 0, 0, 1);
    chk("R5", "narrow three pointers ok", n_ok, 0);
    chk("R5", "narrow three pointers ops", n_ops, 7);
    chk("R5", "narrow three pointers count", n_nloads, 0);
    expect_verdict("R7", 1, 1, 3, 16708);
    send(AL, 23, 22, 20, 1, 0, 0, 0);
    send(BR, 0, 23, 0, 0, 0, 0, 1);
    chk("R5", "narrow overflowed ALU dest ok", n_ok, 0);
    chk("R5", "narrow overflowed ALU dest ops", n_ops, 7);

    summary();
    $finish;
  end

endmodule